// File: doc/BRIEF.md
# Holdoff-Gated Load Strobe Generator

This block turns the rising edge of an end-of-conversion input into a single-clock load strobe for downstream capture logic. Both control inputs, end-of-conversion and line-valid, are already synchronous to the pixel clock. The block keeps a registered copy of each input and compares it with the current value to find edges. It never uses an input as a clock.

A rising edge of end-of-conversion arms a pending request. The request is released as a one-clock strobe only when four conditions hold together: end-of-conversion is high, line-valid is low, and two holdoff timers have both reached the holdoff count. One timer restarts on any edge of end-of-conversion. The other restarts on any edge of line-valid. A clock in which either input changes counts as a fresh restart, so the block never fires in that clock. The timers saturate instead of wrapping.

Top module: `load_strobe_gen`

## Requirements
- R1: While reset is asserted, and in the first clock after it is released, `load_strobe` is 0. Reset clears the pending request. Reset also presets both timers to their saturated value, so a line-valid input that never toggles adds no wait. The registered copies of both inputs reset to 0.
- R2: `load_strobe` is never high for two clocks in a row.
- R3: A strobe appears only in the clock after a clock edge at which `eoc` was sampled 1 and `lval` was sampled 0.
- R4: Suppose `eoc` is sampled at clock edge k with a value different from the one sampled at edge k-1. If no further edge of either input follows and `lval` stays low, the strobe is high for exactly the clock that follows edge k+HOLDOFF+1, and not before.
- R5: An edge of `lval` sampled at edge k likewise blocks firing until edge k+HOLDOFF+1. This holds for both rising and falling edges.
- R6: Each strobe clears the pending request. With no new rising edge of `eoc`, no further strobe appears.
- R7: Extra rising edges of `eoc` while a request is pending do not queue requests. One strobe results.
- R8: A pending request stays armed while `lval` is high. It fires once `lval` has been low and quiet for the holdoff, provided `eoc` is still high.
- R9: A falling edge of `eoc` does not arm a request.
- R10: The holdoff timers saturate. After an arbitrarily long quiet period, a request still fires after the normal holdoff.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Asynchronous reset, active high |
| eoc | input | 1 | End-of-conversion, synchronous to clk |
| lval | input | 1 | Line-valid, synchronous to clk |
| load_strobe | output | 1 | One-clock load pulse |

## Verification
A pending flag that is wrongly set or left set shows at the port as an extra strobe. This can happen on a falling edge, after a previous strobe, or after a repeated rising edge. The strobe appears within HOLDOFF+2 clocks of the last qualifying input edge. A timer that wraps, restarts on the wrong input, or is compared one count off moves the strobe by at least one clock from its predicted slot. The reference model checks every clock, so any such error is caught at the first strobe it affects.

// File: rtl/load_strobe_gen.sv
module load_strobe_gen #(
  parameter int HOLDOFF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic eoc,
  input  logic lval,
  output logic load_strobe
);

  localparam int TW = $clog2(HOLDOFF + 1);
  localparam logic [TW-1:0] TMAX = '1;
  localparam logic [TW-1:0] HOLD = TW'(HOLDOFF);

  logic          eoc_q, lval_q, pend;
  logic [TW-1:0] tmr_e, tmr_l;

  wire eoc_rise = eoc & ~eoc_q;
  wire eoc_chg  = eoc ^ eoc_q;
  wire lval_chg = lval ^ lval_q;
  wire quiet    = ~eoc_chg & ~lval_chg;
  wire fire     = pend & eoc & ~lval & quiet & (tmr_e >= HOLD) & (tmr_l >= HOLD);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      eoc_q       <= 1'b0;
      lval_q      <= 1'b0;
      tmr_e       <= TMAX;
      tmr_l       <= TMAX;
      pend        <= 1'b0;
      load_strobe <= 1'b0;
    end else begin
      eoc_q       <= eoc;
      lval_q      <= lval;
      tmr_e       <= eoc_chg  ? '0 : (tmr_e == TMAX ? TMAX : tmr_e + 1'b1);
      tmr_l       <= lval_chg ? '0 : (tmr_l == TMAX ? TMAX : tmr_l + 1'b1);
      pend        <= fire ? 1'b0 : (pend | eoc_rise);
      load_strobe <= fire;
    end
  end

  assert_single_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    load_strobe |=> !load_strobe);

  assert_levels_R3: assert property (@(posedge clk) disable iff (rst)
    load_strobe |-> ($past(eoc) && !$past(lval)));

  assert_holdoff_R4: assert property (@(posedge clk) disable iff (rst)
    load_strobe |-> ($past(tmr_e) >= HOLD && $past(tmr_l) >= HOLD));

  assert_clear_pending_R6: assert property (@(posedge clk) disable iff (rst)
    load_strobe |-> !pend);

  assert_saturate_R10: assert property (@(posedge clk) disable iff (rst)
    (tmr_e == TMAX) |=> (tmr_e == TMAX || tmr_e == '0));

endmodule

// File: tb/test_load_strobe_gen.sv
module test_load_strobe_gen;
  localparam int H = 4;

  logic clk = 1'b0, rst = 1'b1, eoc = 1'b0, lval = 1'b0;
  logic load_strobe;
  int checks = 0, fails = 0, cycles = 0, pulses = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  load_strobe_gen #(.HOLDOFF(H)) i_load_strobe_gen (
    .clk(clk), .rst(rst), .eoc(eoc), .lval(lval), .load_strobe(load_strobe));

  // reference model: counts of clocks since each input last moved
  bit m_pe, m_pl, m_pend, m_exp;
  int m_se, m_sl;
  always @(posedge clk or posedge rst) begin
    if (rst) begin
      m_pe = 0; m_pl = 0; m_pend = 0; m_exp = 0; m_se = 1000; m_sl = 1000;
    end else begin
      bit ce, cl, f;
      ce = (eoc != m_pe); cl = (lval != m_pl);
      f = m_pend && eoc && !lval && !ce && !cl && m_se >= H && m_sl >= H;
      if (f) m_pend = 0; else if (eoc && !m_pe) m_pend = 1;
      m_se = ce ? 0 : (m_se < 1000 ? m_se + 1 : m_se);
      m_sl = cl ? 0 : (m_sl < 1000 ? m_sl + 1 : m_sl);
      m_pe = eoc; m_pl = lval; m_exp = f;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (load_strobe) pulses++;
    chk({phase, " model"}, int'(load_strobe), int'(m_exp));
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic drive(bit e, bit l, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); eoc = e; lval = l;
    end
  endtask

  task automatic wait_slot(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int p0;
    logic [15:0] lf;
    phase = "R1";
    wait_slot(3);
    chk("R1 strobe in reset", int'(load_strobe), 0);
    @(negedge clk); rst = 1'b0;
    wait_slot(1);
    chk("R1 strobe after release", int'(load_strobe), 0);

    // R4: rise sampled at edge k, strobe after edge k+H+1
    phase = "R4";
    drive(0, 0, 10);
    @(negedge clk); eoc = 1'b1;   // sampled at next edge k
    p0 = pulses;
    for (int j = 1; j <= H + 1; j++) begin
      @(negedge clk);
      chk("R4 no early strobe", int'(load_strobe), 0);
    end
    @(negedge clk);
    chk("R4 strobe slot", int'(load_strobe), 1);
    phase = "R6";
    wait_slot(20);
    chk("R6 one strobe only", pulses - p0, 1);

    // R9: fall does not arm
    phase = "R9";
    p0 = pulses;
    drive(0, 0, 20);
    chk("R9 fall no strobe", pulses - p0, 0);

    // R7: repeated rises while pending
    phase = "R7";
    p0 = pulses;
    drive(1, 1, 2); drive(0, 1, 1); drive(1, 1, 2); drive(0, 1, 1); drive(1, 1, 5);
    drive(1, 0, 20);
    chk("R7 single strobe", pulses - p0, 1);

    // R8 / R5: pending held under lval high, lval fall restarts holdoff
    phase = "R8";
    drive(0, 0, 10);
    p0 = pulses;
    drive(1, 1, 30);
    chk("R8 held while lval high", pulses - p0, 0);
    @(negedge clk); lval = 1'b0;
    phase = "R5";
    for (int j = 1; j <= H + 1; j++) begin
      @(negedge clk);
      chk("R5 lval holdoff", int'(load_strobe), 0);
    end
    @(negedge clk);
    chk("R5 strobe after lval holdoff", int'(load_strobe), 1);

    // R3: eoc drops before holdoff expires -> nothing
    phase = "R3";
    drive(0, 0, 10);
    p0 = pulses;
    drive(1, 0, 2); drive(0, 0, 20);
    chk("R3 eoc low blocks", pulses - p0, 0);

    // R10: long quiet then request
    phase = "R10";
    drive(0, 0, 300);
    p0 = pulses;
    drive(1, 0, 15);
    chk("R10 after long quiet", pulses - p0, 1);

    // R2 and mixed: pseudo-random patterns checked against the model
    phase = "R2";
    lf = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      @(negedge clk);
      if (lf[2:0] == 0) eoc = ~eoc;
      if (lf[7:4] == 0) lval = ~lval;
    end
    drive(0, 0, 10);

    // R1: reset mid-pending
    phase = "R1";
    drive(1, 0, 2);
    @(negedge clk); rst = 1'b1;
    wait_slot(2);
    @(negedge clk); rst = 1'b0; eoc = 1'b0;
    p0 = pulses;
    wait_slot(20);
    chk("R1 reset clears pending", pulses - p0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule